// File: doc/BRIEF.md
# Fixed-Point Transposed IIR Filter

This block is a recursive digital filter for signed fixed-point samples. It accepts one sample per clock and returns one filtered sample per clock. A recursive section runs first and forms an intermediate node v. Both coefficient sets multiply that same node. The denominator terms return through a chain of delay registers into the input adder. The numerator terms build the output through a second chain of delay registers.

All shape information is fixed when the block is instantiated: sample, coefficient and output widths, the fraction length of each, the two tap counts, and both coefficient sets. Denominator coefficients are supplied already sign-adjusted, so their terms are added. The leading denominator coefficient is never used.

The output is combinational from the current registers and v. An input sample therefore shows up on the output in the same cycle, scaled by the leading numerator coefficient. Changing between fixed-point formats handles the integer and fraction fields separately. A wider integer field is sign-extended, a narrower one loses its upper bits, a wider fraction is padded with zeros, and a narrower fraction is truncated toward minus infinity.

Top module: `iir_transposed`

## Requirements
- R1: The node v is sig_in plus feedback register 0, wrapped to IN_W bits, when there are two or more denominator taps. With one denominator tap, v is sig_in itself.
- R2: The output is combinational. With all registers at zero, sig_out equals the resized product of b0 and sig_in in the same cycle. With the defaults, an input of 256 (1.0 in Q4.8) gives 64 (0.25 in Q6.8).
- R3: Each full product is IN_W+COEF_W bits wide. Only its low IN_W+COEF_W-1 bits are kept, in a format with IN_FRAC+COEF_FRAC fraction bits.
- R4: Feedforward register k-1 loads b_k·v plus feedforward register k. The last register loads the bare product. The output uses b0·v plus register 0, or only b0·v when there is a single numerator tap.
- R5: Feedback register k-1 loads a_k·v plus feedback register k, where k ≥ 1. The last register loads the bare product, and these terms are added, not subtracted.
- R6: The product-format value feeding the output is resized to OUT_W bits with OUT_FRAC fraction bits. The fraction is floor-truncated or zero-filled, and the integer field is sign-extended or wrapped.
- R7: Feedback register 0 is IN_W bits wide in the input format. It loads the stage-1 feedback sum resized from the product format, floor-truncating the fraction and wrapping the integer field. All other registers are IN_W+COEF_W-1 bits wide.
- R8: A synchronous reset clears every delay register to zero at the active clock edge. With the input at zero, the output in the cycle after reset is zero.
- R9: The default parameters give a rising-edge clock and an active-high reset. CLK_RISE=0 selects the falling edge, and RST_HIGH=0 selects an active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is set by CLK_RISE |
| rst | input | 1 | Synchronous reset; the active level is set by RST_HIGH |
| sig_in | input | IN_W | Signed input sample, IN_FRAC fraction bits |
| sig_out | output | OUT_W | Signed filtered sample, OUT_FRAC fraction bits |

## Verification
The assertions assume the node v stays inside the input format's range. Outside that range, the wrap on the input adder makes the filter state diverge from the ideal response. The bench keeps its stimulus within that range:
- impulses and steps no larger than 1.0 in magnitude;
- a negative step of about -1.17;
- random samples within ±2.0.

With the default poles at radius 0.5, these inputs keep v well below the ±8 limit. The bench also applies reset only with the input defined, so the assertion that the output is zero after reset is evaluated on a known input.

// File: rtl/iir_transposed.sv
module iir_transposed #(
  parameter int IN_W      = 12,
  parameter int IN_FRAC   = 8,
  parameter int COEF_W    = 10,
  parameter int COEF_FRAC = 8,
  parameter int OUT_W     = 14,
  parameter int OUT_FRAC  = 8,
  parameter int NUM_TAPS  = 3,
  parameter int DEN_TAPS  = 3,
  parameter logic [NUM_TAPS*COEF_W-1:0] B_COEFS = {10'sd64, 10'sd128, 10'sd64},
  parameter logic [DEN_TAPS*COEF_W-1:0] A_COEFS = {-10'sd64, 10'sd128, 10'sd0},
  parameter bit CLK_RISE = 1'b1,
  parameter bit RST_HIGH = 1'b1
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [IN_W-1:0]   sig_in,
  output logic signed [OUT_W-1:0]  sig_out
);
  localparam int PW = IN_W + COEF_W - 1;
  localparam int PF = IN_FRAC + COEF_FRAC;
  localparam int FW = IN_W + COEF_W;
  localparam int WW = PW + OUT_W + IN_W + 2;
  localparam int NB = (NUM_TAPS > 1) ? NUM_TAPS - 1 : 1;
  localparam int NA = (DEN_TAPS > 1) ? DEN_TAPS - 1 : 1;
  localparam int NR = (DEN_TAPS > 2) ? DEN_TAPS - 2 : 1;

  function automatic logic signed [WW-1:0] align(input logic signed [PW-1:0] x, input int dfrac);
    logic signed [WW-1:0] e;
    e = {{(WW-PW){x[PW-1]}}, x};
    if (dfrac >= PF) e = e <<< (dfrac - PF);
    else             e = e >>> (PF - dfrac);
    return e;
  endfunction

  function automatic logic signed [OUT_W-1:0] to_out(input logic signed [PW-1:0] x);
    return OUT_W'(align(x, OUT_FRAC));
  endfunction

  function automatic logic signed [IN_W-1:0] to_in(input logic signed [PW-1:0] x);
    return IN_W'(align(x, IN_FRAC));
  endfunction

  wire clk_i = CLK_RISE ? clk : ~clk;
  wire rst_i = RST_HIGH ? rst : ~rst;

  logic signed [IN_W-1:0] v;
  logic signed [IN_W-1:0] za0;
  logic signed [PW-1:0]   zr    [NR];
  logic signed [PW-1:0]   zb    [NB];
  logic signed [PW-1:0]   pb    [NUM_TAPS];
  logic signed [PW-1:0]   ffsum [NUM_TAPS];
  logic signed [PW-1:0]   pa    [NA];
  logic signed [PW-1:0]   fbsum [NA];

  generate
    if (DEN_TAPS > 1) begin : g_fb_node
      assign v = sig_in + za0;
    end else begin : g_no_fb
      assign v = sig_in;
      assign za0 = '0;
    end

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_ff
      localparam logic signed [COEF_W-1:0] BK = B_COEFS[k*COEF_W +: COEF_W];
      wire signed [FW-1:0] full = v * BK;
      assign pb[k] = PW'(full);
      if (k < NUM_TAPS - 1) begin : g_add
        assign ffsum[k] = pb[k] + zb[k];
      end else begin : g_last
        assign ffsum[k] = pb[k];
      end
    end

    if (NUM_TAPS > 1) begin : g_ff_regs
      always_ff @(posedge clk_i)
        for (int i = 0; i < NUM_TAPS - 1; i++)
          zb[i] <= rst_i ? '0 : ffsum[i+1];
    end else begin : g_ff_none
      assign zb[0] = '0;
    end

    if (DEN_TAPS > 1) begin : g_fb
      for (genvar k = 1; k < DEN_TAPS; k++) begin : g_tap
        localparam logic signed [COEF_W-1:0] AK = A_COEFS[k*COEF_W +: COEF_W];
        wire signed [FW-1:0] full = v * AK;
        assign pa[k-1] = PW'(full);
        if (k < DEN_TAPS - 1) begin : g_add
          assign fbsum[k-1] = pa[k-1] + zr[k-1];
        end else begin : g_last
          assign fbsum[k-1] = pa[k-1];
        end
      end

      always_ff @(posedge clk_i)
        za0 <= rst_i ? '0 : to_in(fbsum[0]);

      if (DEN_TAPS > 2) begin : g_fb_regs
        always_ff @(posedge clk_i)
          for (int i = 0; i < DEN_TAPS - 2; i++)
            zr[i] <= rst_i ? '0 : fbsum[i+1];
      end else begin : g_fb_none
        assign zr[0] = '0;
      end
    end else begin : g_fb_off
      assign pa[0] = '0;
      assign fbsum[0] = '0;
      assign zr[0] = '0;
    end
  endgenerate

  assign sig_out = to_out(ffsum[0]);
endmodule

// File: rtl/iir_transposed_chk.sv
module iir_transposed_chk #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 14,
  parameter int PW    = 21
)(
  input logic                    clk,
  input logic                    rst,
  input logic signed [IN_W-1:0]  sig_in,
  input logic signed [OUT_W-1:0] sig_out,
  input logic signed [IN_W-1:0]  v,
  input logic signed [IN_W-1:0]  za0,
  input logic signed [PW-1:0]    zb_first
);
  AST_RST_CLEARS_FB: assert property (@(posedge clk) rst |=> (za0 == '0)); // R8
  AST_RST_ZERO_OUT: assert property (@(posedge clk) rst |=> (sig_in != '0 || sig_out == '0)); // R8
  AST_ZERO_STATE_PASS: assert property (@(posedge clk) disable iff (rst) (za0 == '0) |-> (v == sig_in)); // R1
  AST_QUIET_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (za0 == '0 && zb_first == '0 && sig_in == '0) |-> (sig_out == '0)); // R2
endmodule

bind iir_transposed iir_transposed_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .sig_in(sig_in), .sig_out(sig_out),
  .v(v), .za0(za0), .zb_first(zb[0])
);

// File: tb/iir_transposed_test.sv
module iir_transposed_test;
  localparam int IW = 12;
  localparam int OW = 14;
  localparam int PW = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [IW-1:0] sig_in = '0;
  logic signed [OW-1:0] sig_out;

  always #2 clk = ~clk;

  iir_transposed uut (.clk(clk), .rst(rst), .sig_in(sig_in), .sig_out(sig_out));

  longint m_zb0 = 0, m_zb1 = 0, m_za0 = 0, m_zr0 = 0;
  longint exp_q[$];
  string  tag_q[$];
  int tests = 0, fails = 0;
  bit done = 1'b0;

  function automatic longint wrap(input longint x, input int w);
    longint m;
    m = x & ((64'sd1 <<< w) - 1);
    if (((m >>> (w - 1)) & 1) != 0) m = m - (64'sd1 <<< w);
    return m;
  endfunction

  // Reference: b = {0.25,0.5,0.25}, a1 = +0.5, a2 = -0.25 (Q2.8); products Q5.16
  task automatic step(input longint x, input bit r, input string tag);
    longint v, p0, p1, p2, q1, q2, y;
    @(negedge clk);
    sig_in = IW'(x);
    rst = r;
    v  = wrap(x + m_za0, IW);
    p0 = wrap(v * 64, PW);
    p1 = wrap(v * 128, PW);
    p2 = wrap(v * 64, PW);
    q1 = wrap(v * 128, PW);
    q2 = wrap(v * -64, PW);
    y  = wrap(wrap(p0 + m_zb0, PW) >>> 8, OW);
    exp_q.push_back(y);
    tag_q.push_back(tag);
    if (r) begin
      m_zb0 = 0; m_zb1 = 0; m_za0 = 0; m_zr0 = 0;
    end else begin
      m_zb0 = wrap(p1 + m_zb1, PW);
      m_zb1 = p2;
      m_za0 = wrap(wrap(q1 + m_zr0, PW) >>> 8, IW);
      m_zr0 = q2;
    end
  endtask

  initial begin : monitor
    longint e, got;
    string t;
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = sig_out;
        tests++;
        if (got != e) begin
          fails++;
          $display("FAIL %s: sig_out=%0d expected=%0d", t, got, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 3; i++) step(0, 1'b1, "R8 R9 reset state");
    step(256, 1'b0, "R2 impulse head");
    for (int i = 0; i < 20; i++) step(0, 1'b0, "R4 R5 impulse tail");
    step(0, 1'b1, "R8 reset before step");
    for (int i = 0; i < 30; i++) step(256, 1'b0, "R1 R7 unit step");
    step(0, 1'b1, "R8 reset before negative step");
    for (int i = 0; i < 20; i++) step(-300, 1'b0, "R6 negative floor");
    for (int i = 0; i < 100; i++) step(longint'($urandom_range(0, 1024)) - 512, 1'b0, "R3 random");
    step(0, 1'b1, "R8 mid-run reset");
    step(0, 1'b0, "R8 zero after reset");
    step(100, 1'b0, "R2 R8 fresh sample");
    for (int i = 0; i < 5; i++) step(0, 1'b0, "R4 R5 decay");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule